// File: doc/BRIEF.md
# Three-Product Complex Multiplier

This block multiplies two signed complex operands, x = x_re + j·x_im and y = y_re + j·y_im, and delivers the full-precision real and imaginary parts of their product. The real part ac − bd and the imaginary part ad + bc are formed with three real products instead of four. A single cross product, (x_re − x_im)·y_im, is computed once and added to both outputs. Two pre-adders, y_re − y_im and y_re + y_im, supply the other two products.

The datapath is a fixed four-stage pipeline: an input register, a pre-add register, a product register and a post-add register. A new operand pair may be presented on every cycle. A qualifying strobe travels beside the data, so the strobe on the outputs marks exactly the cycles that carry a result. Operand widths are parameters. With the defaults, the x operand is 26 bits and the y operand is 17 bits, so each pre-added term fits a 27 × 18 signed product. Each result is 45 bits wide and no bits are dropped.

Top module: `cmul3`

## Requirements
- R1: z_re equals x_re·y_re − x_im·y_im as a signed two's-complement value of width AW+BW+2 (45 bits by default), with no truncation.
- R2: z_im equals x_re·y_im + x_im·y_re as a signed two's-complement value of the same width, with no truncation.
- R3: Operands sampled at rising edge k are the ones reflected on z_re and z_im after rising edge k+3. This is a latency of four cycles.
- R4: out_valid after rising edge k+3 equals in_valid sampled at rising edge k. Operands may stream on every cycle or with gaps, and each result keeps its own strobe.
- R5: While rst_n is low at a rising edge, that edge clears out_valid and both outputs to zero. This includes a reset that arrives while results are in flight, and none of those results appears after reset is released.
- R6: Operands at the extremes of their ranges, including the most negative value of every input, give the exact product without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operands as a sample to compute |
| x_re | input | AW | Real part of operand x, signed |
| x_im | input | AW | Imaginary part of operand x, signed |
| y_re | input | BW | Real part of operand y, signed |
| y_im | input | BW | Imaginary part of operand y, signed |
| out_valid | output | 1 | Marks a result on z_re / z_im |
| z_re | output | AW+BW+2 | Real part of the product, signed |
| z_im | output | AW+BW+2 | Imaginary part of the product, signed |

## Verification
The bench drives operands where every input sits at its most negative or most positive value. A pre-adder or product register one bit too narrow would wrap there and return a result with the wrong sign. It also uses inputs where only one cross term is nonzero, which exposes a shared term that was subtracted where it should have been added, or the real and imaginary paths swapped. Streams with gaps in the strobe show whether a strobe pipeline one stage too long or too short has drifted from the data. A reset asserted while results are in flight shows whether the design lets stale results appear after reset.

// File: rtl/cmul3.sv
module cmul3 #(
  parameter int AW = 26,
  parameter int BW = 17,
  localparam int PW = AW + BW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [AW-1:0] x_re,
  input  logic signed [AW-1:0] x_im,
  input  logic signed [BW-1:0] y_re,
  input  logic signed [BW-1:0] y_im,
  output logic                 out_valid,
  output logic signed [PW-1:0] z_re,
  output logic signed [PW-1:0] z_im
);
  localparam int LAT = 4;
  localparam int XW  = AW + 1;
  localparam int YW  = BW + 1;

  logic [LAT-1:0] vpipe;

  logic signed [AW-1:0] a0, b0, a1, b1;
  logic signed [BW-1:0] c0, d0, d1;
  logic signed [XW-1:0] ab_dif;
  logic signed [YW-1:0] cd_dif, cd_sum;
  logic signed [PW-1:0] p_shr, p_re, p_im;

  always_ff @(posedge clk) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a0 <= '0; b0 <= '0; c0 <= '0; d0 <= '0;
      a1 <= '0; b1 <= '0; d1 <= '0;
      ab_dif <= '0; cd_dif <= '0; cd_sum <= '0;
      p_shr <= '0; p_re <= '0; p_im <= '0;
      z_re <= '0; z_im <= '0;
    end else begin
      a0 <= x_re;
      b0 <= x_im;
      c0 <= y_re;
      d0 <= y_im;

      ab_dif <= XW'(a0) - XW'(b0);
      cd_dif <= YW'(c0) - YW'(d0);
      cd_sum <= YW'(c0) + YW'(d0);
      a1 <= a0;
      b1 <= b0;
      d1 <= d0;

      p_shr <= PW'(ab_dif) * PW'(d1);
      p_re  <= PW'(cd_dif) * PW'(a1);
      p_im  <= PW'(cd_sum) * PW'(b1);

      z_re <= p_re + p_shr;
      z_im <= p_im + p_shr;
    end
  end
endmodule

module cmul3_chk #(
  parameter int AW = 26,
  parameter int BW = 17,
  localparam int PW = AW + BW + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [AW-1:0] x_re,
  input logic signed [AW-1:0] x_im,
  input logic signed [BW-1:0] y_re,
  input logic signed [BW-1:0] y_im,
  input logic                 out_valid,
  input logic signed [PW-1:0] z_re,
  input logic signed [PW-1:0] z_im
);
  logic [2:0] since_rst;
  logic signed [PW-1:0] er [4];
  logic signed [PW-1:0] ei [4];

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  always_ff @(posedge clk) begin
    er[0] <= PW'(x_re) * PW'(y_re) - PW'(x_im) * PW'(y_im);
    ei[0] <= PW'(x_re) * PW'(y_im) + PW'(x_im) * PW'(y_re);
    for (int i = 1; i < 4; i++) begin
      er[i] <= er[i-1];
      ei[i] <= ei[i-1];
    end
  end

  assert_real_part_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && out_valid) |-> z_re == er[3]);

  assert_imag_part_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && out_valid) |-> z_im == ei[3]);

  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> out_valid == $past(in_valid, 4));

  assert_quiet_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 3'd4) |-> !out_valid);
endmodule

bind cmul3 cmul3_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
  .out_valid(out_valid), .z_re(z_re), .z_im(z_im)
);

// File: tb/cmul3_tb.sv
module cmul3_tb;
  localparam int AW = 26;
  localparam int BW = 17;
  localparam int PW = AW + BW + 2;
  localparam int NV = 10;

  localparam longint VA [NV] = '{3, -7, 1000000, 0, 33554431, -33554432, -33554432, 12345678, 1, 0};
  localparam longint VB [NV] = '{4, 2, -2000000, 0, 33554431, -33554432, 33554431, -8765432, 0, 1};
  localparam longint VC [NV] = '{5, 9, 30000, 0, 65535, -65536, -65536, -1234, 0, 1};
  localparam longint VD [NV] = '{6, -11, -40000, 0, 65535, -65536, 65535, 4321, 1, 0};
  localparam bit     VX [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [AW-1:0] x_re = '0, x_im = '0;
  logic signed [BW-1:0] y_re = '0, y_im = '0;
  logic out_valid;
  logic signed [PW-1:0] z_re, z_im;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic   mv [4];
  longint mre [4];
  longint mim [4];
  bit     mx [4];

  always #2 clk = ~clk;

  cmul3 #(.AW(AW), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .out_valid(out_valid), .z_re(z_re), .z_im(z_im)
  );

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin
      mv[i] = 1'b0; mre[i] = 0; mim[i] = 0; mx[i] = 1'b0;
    end
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== mv[3]) begin
      fails++;
      $display("FAIL R4 out_valid actual %0b expected %0b", out_valid, mv[3]);
    end
    if (mv[3]) begin
      checks++;
      if (longint'(z_re) != mre[3]) begin
        fails++;
        $display("FAIL %s z_re actual %0d expected %0d", mx[3] ? "R6" : "R1", longint'(z_re), mre[3]);
      end
      checks++;
      if (longint'(z_im) != mim[3]) begin
        fails++;
        $display("FAIL %s z_im actual %0d expected %0d", mx[3] ? "R6" : "R2", longint'(z_im), mim[3]);
      end
    end
  endtask

  task automatic step(input logic v, input longint a, input longint b,
                      input longint c, input longint d, input bit corner);
    @(negedge clk);
    compare();
    for (int i = 3; i > 0; i--) begin
      mv[i] = mv[i-1]; mre[i] = mre[i-1]; mim[i] = mim[i-1]; mx[i] = mx[i-1];
    end
    mv[0] = v;
    mre[0] = a * c - b * d;
    mim[0] = a * d + b * c;
    mx[0] = corner;
    in_valid = v;
    x_re = AW'(a); x_im = AW'(b);
    y_re = BW'(c); y_im = BW'(d);
  endtask

  task automatic check_reset_state();
    checks++;
    if (out_valid !== 1'b0 || z_re !== '0 || z_im !== '0) begin
      fails++;
      $display("FAIL R5 reset state actual v=%0b re=%0d im=%0d expected v=0 re=0 im=0",
               out_valid, longint'(z_re), longint'(z_im));
    end
  endtask

  initial begin
    clear_model();
    in_valid = 1'b1;
    x_re = 26'sd5; y_re = 17'sd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    in_valid = 1'b0;

    // R1 R2 R3 R6: back-to-back stream through the vector table
    for (int i = 0; i < NV; i++) step(1'b1, VA[i], VB[i], VC[i], VD[i], VX[i]);
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 0, 1'b0);

    // R4: gaps in the strobe, data still toggling on idle cycles
    for (int i = 0; i < 2 * NV; i++)
      step(logic'(i % 3 != 1), VA[i % NV], VB[(i + 3) % NV], VC[(i + 5) % NV], VD[i % NV],
           VX[i % NV] && VX[(i + 3) % NV]);
    for (int i = 0; i < 5; i++) step(1'b0, 11, 22, 33, 44, 1'b0);

    // R5: reset while results are in flight
    step(1'b1, VA[4], VB[4], VC[4], VD[4], 1'b1);
    step(1'b1, VA[2], VB[2], VC[2], VD[2], 1'b0);
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    in_valid = 1'b0;
    clear_model();
    for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 0, 0, 1'b0);

    // R3: single isolated sample after reset
    step(1'b1, -33554432, 33554431, 65535, -65536, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule